// File: doc/BRIEF.md
# Loop Miss-Sequence Record and Replay Prefetcher

This block is the prefetch engine for one hardware thread; a core instantiates one copy per thread, and the copies share nothing. Software brackets a region of code, typically a nest of loops, with a start directive and a stop directive. A mode bit that comes with the start directive chooses between capturing a new list and replaying the current one.

In capture mode the engine appends every L1 miss line address to a list, in arrival order. In replay mode it streams the stored list out as prefetch requests and keeps a bounded lookahead ahead of a play pointer. It compares each real miss against a short window of upcoming list entries. A match moves the play pointer past the matched entry, so entries whose misses no longer occur are skipped. A miss that matches nothing in the window is taken as a new, extra miss and leaves the pointer where it is.

Every miss seen during a pass, in capture or in replay, is written into a second list bank. At the stop directive that bank becomes the current list, so each replay pass leaves behind a list refined to the misses that actually occurred.

Top module: `listpf_engine`

## Requirements
- R1: Reset clears the prefetch output and the overflow flag, puts the engine at rest, and empties the list, so a replay started after reset issues no prefetches.
- R2: A start with mode_i=0 begins a capture. Each miss_valid_i cycle appends miss_line_i in order. A stop ends the list. Misses that arrive while the engine is at rest are not stored.
- R3: A start with mode_i=1 begins a replay. The cycle after the start is accepted, the engine presents list entries from the head, one per clock on pf_valid_o/pf_line_o.
- R4: A prefetch is issued only for a list index below play pointer + AHEAD (AHEAD=4). With no miss arriving, prefetching stalls at that limit.
- R5: A miss equal to one of the WIN (=4) list entries starting at the play pointer moves the pointer to one past the lowest matching entry. The entries it passes over are dropped from further prefetching.
- R6: A miss that equals none of those WIN entries leaves the play pointer unchanged.
- R7: After a replay pass ends with a stop, the list holds exactly the misses observed during that pass, in order.
- R8: Once the play pointer reaches the end of the list, no further prefetches are issued, but misses are still recorded until the stop.
- R9: A list holds at most DEPTH entries. A miss that arrives while the list is full is dropped and sets overflow_o, which stays set until the next accepted start clears it.
- R10: A start that arrives while the engine is busy is ignored and the pass continues. A stop that arrives while the engine is at rest is ignored and the current list is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start directive, accepted only when at rest |
| mode_i | input | 1 | 0 = capture a new list, 1 = replay the current list |
| stop_i | input | 1 | Stop directive; ends the pass and installs the new list |
| miss_valid_i | input | 1 | An L1 miss is presented this cycle |
| miss_line_i | input | LINE_W | Line address of the miss |
| pf_valid_o | output | 1 | Prefetch request valid |
| pf_line_o | output | LINE_W | Line address to prefetch |
| overflow_o | output | 1 | A miss was dropped because the list was full |

## Verification
The assertions assume that start and stop are never raised in the same cycle. They also assume that miss_line_i holds a known value whenever miss_valid_i is high, and that WIN and AHEAD stay below DEPTH so that the pointer sums never wrap. The stimulus table drives each directive for a single cycle and never pairs start with stop. It keeps every address a small known constant. It runs with an eight-entry list, so the lookahead limit, the window edge, list exhaustion and overflow are all reached within a few dozen cycles.

// File: rtl/listpf_pkg.sv
package listpf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REC  = 2'd1,
    ST_PLAY = 2'd2,
    ST_DONE = 2'd3
  } eng_state_e;
endpackage

// File: rtl/listpf_bank.sv
// One list bank: a flop array with one write port and NRD combinational read ports.
module listpf_bank #(
  parameter int DEPTH  = 1024,
  parameter int LINE_W = 26,
  parameter int NRD    = 5,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                        clk,
  input  logic                        we_i,
  input  logic [AW-1:0]               waddr_i,
  input  logic [LINE_W-1:0]           wdata_i,
  input  logic [NRD-1:0][AW-1:0]      raddr_i,
  output logic [NRD-1:0][LINE_W-1:0]  rdata_o
);
  logic [LINE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata_o[r] = mem_q[raddr_i[r]];
  end
endmodule

// File: rtl/listpf_match.sv
// Compares a miss against the alignment window; the lowest matching offset wins.
module listpf_match #(
  parameter int LINE_W = 26,
  parameter int WIN    = 4,
  localparam int OFF_W = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic [LINE_W-1:0]           miss_line_i,
  input  logic [WIN-1:0][LINE_W-1:0]  win_line_i,
  input  logic [WIN-1:0]              win_valid_i,
  output logic                        hit_o,
  output logic [OFF_W-1:0]            off_o
);
  logic [WIN-1:0] eq;

  for (genvar k = 0; k < WIN; k++) begin : g_cmp
    assign eq[k] = win_valid_i[k] && (win_line_i[k] == miss_line_i);
  end

  always_comb begin
    hit_o = 1'b0;
    off_o = '0;
    for (int k = WIN - 1; k >= 0; k--) begin
      if (eq[k]) begin
        hit_o = 1'b1;
        off_o = OFF_W'(k);
      end
    end
  end
endmodule

// File: rtl/listpf_engine.sv
module listpf_engine
  import listpf_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int DEPTH  = 1024,
  parameter int WIN    = 4,
  parameter int AHEAD  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              stop_i,
  input  logic              miss_valid_i,
  input  logic [LINE_W-1:0] miss_line_i,
  output logic              pf_valid_o,
  output logic [LINE_W-1:0] pf_line_o,
  output logic              overflow_o
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PW    = CNT_W + 1;
  localparam int OFF_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int NRD   = WIN + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // state
  eng_state_e        state_q, state_d;
  logic              bank_q, bank_d;
  logic [CNT_W-1:0]  len_q, len_d;
  logic [CNT_W-1:0]  play_q, play_d;
  logic [CNT_W-1:0]  pfp_q, pfp_d;
  logic [CNT_W-1:0]  wr_q, wr_d;
  logic              ovf_q, ovf_d;
  logic              pfv_q, pfv_d;
  logic [LINE_W-1:0] pfl_q, pfl_d;

  // list storage: two banks, read the current one, write the refined one
  logic [NRD-1:0][AW-1:0]     raddr;
  logic [NRD-1:0][LINE_W-1:0] rd_bank [2];
  logic [NRD-1:0][LINE_W-1:0] rd_sel;
  logic [1:0]                 we_b;
  logic                       mem_we;
  logic [AW-1:0]              waddr;

  assign waddr   = wr_q[AW-1:0];
  assign we_b[0] = mem_we & bank_q;
  assign we_b[1] = mem_we & ~bank_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    listpf_bank #(.DEPTH(DEPTH), .LINE_W(LINE_W), .NRD(NRD)) u_bank (
      .clk     (clk),
      .we_i    (we_b[b]),
      .waddr_i (waddr),
      .wdata_i (miss_line_i),
      .raddr_i (raddr),
      .rdata_o (rd_bank[b])
    );
  end
  assign rd_sel = rd_bank[bank_q];

  // alignment window
  logic [WIN-1:0][PW-1:0]     win_idx;
  logic [WIN-1:0][LINE_W-1:0] win_line;
  logic [WIN-1:0]             win_valid;
  logic                       hit;
  logic [OFF_W-1:0]           off;

  for (genvar k = 0; k < WIN; k++) begin : g_win
    assign win_idx[k]   = {1'b0, play_q} + PW'(k);
    assign win_valid[k] = win_idx[k] < {1'b0, len_q};
    assign raddr[k]     = win_idx[k][AW-1:0];
    assign win_line[k]  = rd_sel[k];
  end

  listpf_match #(.LINE_W(LINE_W), .WIN(WIN)) u_match (
    .miss_line_i (miss_line_i),
    .win_line_i  (win_line),
    .win_valid_i (win_valid),
    .hit_o       (hit),
    .off_o       (off)
  );

  // play pointer advance and prefetch selection
  logic             busy_miss;
  logic [CNT_W-1:0] play_adv;
  logic [CNT_W-1:0] base;
  logic [PW-1:0]    lim_w;
  logic             can_pf;
  logic             room;

  assign busy_miss = (state_q != ST_IDLE) && miss_valid_i && !stop_i;
  assign room      = wr_q < CNT_W'(DEPTH);
  assign mem_we    = busy_miss && room;

  always_comb begin
    play_adv = play_q;
    if (state_q == ST_PLAY && busy_miss && hit) begin
      play_adv = play_q + CNT_W'(off) + CNT_W'(1);
    end
  end

  assign base       = (pfp_q > play_adv) ? pfp_q : play_adv;
  assign lim_w      = {1'b0, play_adv} + PW'(AHEAD);
  assign can_pf     = (base < len_q) && ({1'b0, base} < lim_w);
  assign raddr[WIN] = base[AW-1:0];

  // next state
  always_comb begin
    state_d = state_q;
    bank_d  = bank_q;
    len_d   = len_q;
    play_d  = play_q;
    pfp_d   = pfp_q;
    wr_d    = wr_q;
    ovf_d   = ovf_q;
    pfv_d   = 1'b0;
    pfl_d   = pfl_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = mode_i ? ST_PLAY : ST_REC;
          wr_d    = '0;
          ovf_d   = 1'b0;
          play_d  = '0;
          pfp_d   = '0;
        end
      end
      ST_REC, ST_PLAY, ST_DONE: begin
        if (stop_i) begin
          state_d = ST_IDLE;
          bank_d  = ~bank_q;
          len_d   = wr_q;
        end else begin
          if (miss_valid_i) begin
            if (room) wr_d  = wr_q + CNT_W'(1);
            else      ovf_d = 1'b1;
          end
          if (state_q == ST_PLAY) begin
            play_d = play_adv;
            if (can_pf) begin
              pfv_d = 1'b1;
              pfl_d = rd_sel[WIN];
              pfp_d = base + CNT_W'(1);
            end else begin
              pfp_d = base;
            end
            if (play_adv >= len_q) state_d = ST_DONE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      bank_q  <= 1'b0;
      len_q   <= '0;
      play_q  <= '0;
      pfp_q   <= '0;
      wr_q    <= '0;
      ovf_q   <= 1'b0;
      pfv_q   <= 1'b0;
      pfl_q   <= '0;
    end else begin
      state_q <= state_d;
      bank_q  <= bank_d;
      len_q   <= len_d;
      play_q  <= play_d;
      pfp_q   <= pfp_d;
      wr_q    <= wr_d;
      ovf_q   <= ovf_d;
      pfv_q   <= pfv_d;
      if (pfv_d) pfl_q <= pfl_d;
    end
  end

  assign pf_valid_o = pfv_q;
  assign pf_line_o  = pfl_q;
  assign overflow_o = ovf_q;

  // checks
  assert_pf_in_play_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    pf_valid_o |-> $past(state_q == ST_PLAY));

  assert_lookahead_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_PLAY) |-> ({1'b0, pfp_q} <= {1'b0, play_q} + PW'(AHEAD)));

  assert_play_forward_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q != ST_IDLE) && $past(state_q != ST_IDLE) |-> (play_q >= $past(play_q)));

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_DONE) |=> !pf_valid_o);

  assert_list_bound_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_q <= CNT_W'(DEPTH));

  assert_ovf_when_full_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(ovf_q) |-> ($past(wr_q) == CNT_W'(DEPTH)));

  assert_rec_holds_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_REC) && !stop_i |=> (state_q == ST_REC));
endmodule

// File: tb/listpf_engine_bench.sv
`timescale 1ns/1ps
module listpf_engine_bench;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i, mode_i, stop_i, miss_valid_i;
  logic [LW-1:0] miss_line_i;
  logic          pf_valid_o, overflow_o;
  logic [LW-1:0] pf_line_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  listpf_engine #(.LINE_W(LW), .DEPTH(8), .WIN(4), .AHEAD(4)) u_listpf_engine (
    .clk, .rst_n, .start_i, .mode_i, .stop_i, .miss_valid_i, .miss_line_i,
    .pf_valid_o, .pf_line_o, .overflow_o
  );

  typedef struct packed {
    bit          st;
    bit          md;
    bit          sp;
    bit          mv;
    bit [LW-1:0] ml;
    bit          epv;
    bit [LW-1:0] epl;
    bit          eovf;
    bit [7:0]    req;
  } vec_t;

  localparam int NV = 60;
  localparam vec_t VEC [NV] = '{
    '{1,0,0,0,16'd0 ,0,16'd0 ,0,8'd2},  // R2 start capture
    '{0,0,0,1,16'd10,0,16'd0 ,0,8'd2},
    '{0,0,0,1,16'd11,0,16'd0 ,0,8'd2},
    '{0,0,0,1,16'd12,0,16'd0 ,0,8'd2},
    '{0,0,0,0,16'd0 ,0,16'd0 ,0,8'd2},
    '{0,0,0,1,16'd13,0,16'd0 ,0,8'd2},
    '{0,0,0,1,16'd14,0,16'd0 ,0,8'd2},
    '{0,0,0,1,16'd15,0,16'd0 ,0,8'd2},
    '{0,0,1,0,16'd0 ,0,16'd0 ,0,8'd2},  // R2 stop
    '{0,0,0,1,16'd99,0,16'd0 ,0,8'd2},  // R2 idle miss dropped
    '{0,0,1,0,16'd0 ,0,16'd0 ,0,8'd10}, // R10 stop at rest
    '{1,1,0,0,16'd0 ,0,16'd0 ,0,8'd3},  // R3 start replay
    '{0,0,0,0,16'd0 ,1,16'd10,0,8'd3},
    '{0,0,0,0,16'd0 ,1,16'd11,0,8'd3},
    '{0,0,0,0,16'd0 ,1,16'd12,0,8'd3},
    '{0,0,0,0,16'd0 ,1,16'd13,0,8'd3},
    '{0,0,0,0,16'd0 ,0,16'd0 ,0,8'd4},  // R4 lookahead limit
    '{0,0,0,1,16'd10,1,16'd14,0,8'd4},
    '{0,0,0,1,16'd12,1,16'd15,0,8'd5},  // R5 skip missing 11
    '{0,0,0,1,16'd77,0,16'd0 ,0,8'd6},  // R6 extra miss
    '{0,0,0,1,16'd13,0,16'd0 ,0,8'd5},
    '{0,0,0,1,16'd14,0,16'd0 ,0,8'd5},
    '{0,0,0,1,16'd15,0,16'd0 ,0,8'd8},  // R8 list end
    '{0,0,0,1,16'd16,0,16'd0 ,0,8'd8},
    '{0,0,1,0,16'd0 ,0,16'd0 ,0,8'd7},
    '{1,1,0,0,16'd0 ,0,16'd0 ,0,8'd7},  // R7 refined list replay
    '{0,0,0,0,16'd0 ,1,16'd10,0,8'd7},
    '{0,0,0,0,16'd0 ,1,16'd12,0,8'd7},
    '{0,0,0,0,16'd0 ,1,16'd77,0,8'd7},
    '{0,0,0,0,16'd0 ,1,16'd13,0,8'd7},
    '{0,0,0,0,16'd0 ,0,16'd0 ,0,8'd4},
    '{0,0,0,1,16'd10,1,16'd14,0,8'd7},
    '{0,0,0,1,16'd12,1,16'd15,0,8'd7},
    '{0,0,0,1,16'd77,1,16'd16,0,8'd7},
    '{0,0,0,0,16'd0 ,0,16'd0 ,0,8'd8},
    '{0,0,1,0,16'd0 ,0,16'd0 ,0,8'd7},
    '{1,0,0,0,16'd0 ,0,16'd0 ,0,8'd9},  // R9 capture to full
    '{0,0,0,1,16'd20,0,16'd0 ,0,8'd9},
    '{1,1,0,1,16'd21,0,16'd0 ,0,8'd10}, // R10 start while busy
    '{0,0,0,1,16'd22,0,16'd0 ,0,8'd9},
    '{0,0,0,1,16'd23,0,16'd0 ,0,8'd9},
    '{0,0,0,1,16'd24,0,16'd0 ,0,8'd9},
    '{0,0,0,1,16'd25,0,16'd0 ,0,8'd9},
    '{0,0,0,1,16'd26,0,16'd0 ,0,8'd9},
    '{0,0,0,1,16'd27,0,16'd0 ,0,8'd9},
    '{0,0,0,1,16'd28,0,16'd0 ,1,8'd9},  // R9 overflow
    '{0,0,1,0,16'd0 ,0,16'd0 ,1,8'd9},
    '{1,1,0,0,16'd0 ,0,16'd0 ,0,8'd9},  // R9 cleared by start
    '{0,0,0,0,16'd0 ,1,16'd20,0,8'd10},
    '{0,0,0,0,16'd0 ,1,16'd21,0,8'd10},
    '{0,0,0,0,16'd0 ,1,16'd22,0,8'd10},
    '{0,0,0,0,16'd0 ,1,16'd23,0,8'd10},
    '{0,0,0,0,16'd0 ,0,16'd0 ,0,8'd4},
    '{0,0,0,1,16'd24,0,16'd0 ,0,8'd6},  // R6 beyond window
    '{0,0,0,1,16'd23,1,16'd24,0,8'd5},  // R5 last window slot
    '{0,0,0,0,16'd0 ,1,16'd25,0,8'd4},
    '{0,0,0,0,16'd0 ,1,16'd26,0,8'd4},
    '{0,0,0,0,16'd0 ,1,16'd27,0,8'd4},
    '{0,0,0,0,16'd0 ,0,16'd0 ,0,8'd8},
    '{0,0,1,0,16'd0 ,0,16'd0 ,0,8'd8}
  };

  task automatic drive(input vec_t v);
    start_i      = v.st;
    mode_i       = v.md;
    stop_i       = v.sp;
    miss_valid_i = v.mv;
    miss_line_i  = v.ml;
  endtask

  task automatic quiet();
    start_i = 0; mode_i = 0; stop_i = 0; miss_valid_i = 0; miss_line_i = '0;
  endtask

  task automatic check_out(input int req, input int row, input bit epv,
                           input logic [LW-1:0] epl, input bit eovf);
    checks++;
    if (pf_valid_o !== epv) begin
      errors++;
      $display("FAIL R%0d row %0d pf_valid actual %0b expected %0b", req, row, pf_valid_o, epv);
    end
    if (epv) begin
      checks++;
      if (pf_line_o !== epl) begin
        errors++;
        $display("FAIL R%0d row %0d pf_line actual %0d expected %0d", req, row, pf_line_o, epl);
      end
    end
    checks++;
    if (overflow_o !== eovf) begin
      errors++;
      $display("FAIL R%0d row %0d overflow actual %0b expected %0b", req, row, overflow_o, eovf);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    quiet();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_out(1, -1, 0, '0, 0);  // R1 outputs during reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_out(1, -1, 0, '0, 0);  // R1 state after reset

    drive(VEC[0]);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check_out(int'(VEC[i].req), i, VEC[i].epv, VEC[i].epl, VEC[i].eovf);
      if (i + 1 < NV) drive(VEC[i + 1]);
      else            quiet();
    end

    // R1: reset in the middle of a replay empties the list
    drive('{1,1,0,0,16'd0,0,16'd0,0,8'd1});
    @(negedge clk);
    quiet();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_out(1, 100, 0, '0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    start_i = 1; mode_i = 1;
    @(negedge clk);
    quiet();
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      check_out(1, 101 + j, 0, '0, 0);  // R1 no prefetch from an empty list
    end
    stop_i = 1;
    @(negedge clk);
    quiet();
    @(negedge clk);
    finish_run();
  end
endmodule